// File: doc/BRIEF.md
# Strand Pause Delay Counter

This block stalls one hardware thread for a programmed number of clock cycles. A single write hands it a cycle count; from the next clock edge the block holds its stall output high, and the issue logic uses that output to keep the thread from issuing. It is meant for retry loops that have to wait, such as an atomic operation that keeps losing a race and backs off for longer each time.

The count is not kept to the exact cycle. The block drops the three low bits of the written value and loads the rest into a down-counter. The counter steps down once every eight clocks, so a stall always lasts a whole number of eight-cycle units. A nonzero value too small to fill one unit still gives a stall of one cycle. A write of zero gives no stall. A pending disrupting trap ends the stall at the next edge, whatever count remains.

Top module: `strand_pause_timer`

## Requirements
- R1: After reset, and before any write, `stall_o` is low.
- R2: A write with `wr_data_i >= 8` and `trap_i` low sets `stall_o` high at the clock edge that takes the write. `stall_o` then stays high for exactly 8 * (`wr_data_i` >> 3) consecutive cycles.
- R3: Bits [2:0] of a write of 8 or more do not change the stall length. Values that differ only in those bits give equal stalls.
- R4: A write with `wr_data_i` from 1 to 7 raises `stall_o` for exactly one cycle.
- R5: A write of zero gives no stall. A write of zero during a stall clears `stall_o` at the edge that takes it.
- R6: `trap_i` high at a clock edge clears `stall_o` at that edge, and the stall does not resume. `trap_i` takes priority over a write in the same cycle.
- R7: A write during a stall reloads the count and restarts the eight-cycle step. The stall then lasts exactly as long as that write would give from idle.
- R8: The count keeps all 61 upper bits of the 64-bit value. A write with bit 63 set stalls for far longer than any count that fits in fewer bits, until a trap arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Write strobe for the pause count |
| wr_data_i | input | 64 | Requested stall length in cycles |
| trap_i | input | 1 | Disrupting trap pending; ends the stall |
| stall_o | output | 1 | Registered stall request to the issue logic |

## Verification
The stall length is measured for every written value from 0 to 255, each one written from idle. This separates the no-stall case, the one-cycle case and the whole-unit cases. It also shows that the values inside each group of eight give the same length. Other writes land in the middle of a running stall: a longer or shorter count, a small value and a zero. These tell a true reload, with the step phase restarted, apart from a count that only adds to the old one or keeps the old phase. Traps are applied in the middle of a stall and together with a write, and a write with bit 63 set is followed by a trap. Together these show that the abort wins and that the top bits of the count are kept.

// File: rtl/strand_pause_pkg.sv
package strand_pause_pkg;

  typedef enum logic [1:0] {
    WR_NONE  = 2'd0,
    WR_ZERO  = 2'd1,
    WR_SHORT = 2'd2,
    WR_LONG  = 2'd3
  } wr_kind_e;

endpackage

// File: rtl/pause_decode.sv
module pause_decode
  import strand_pause_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SHIFT  = 3,
  localparam int CNT_W = DATA_W - SHIFT
) (
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output wr_kind_e          kind_o,
  output logic [CNT_W-1:0]  load_val_o
);

  logic [CNT_W-1:0] units;
  logic             frac_nz;

  assign units      = wr_data_i[DATA_W-1:SHIFT];
  assign frac_nz    = |wr_data_i[SHIFT-1:0];
  assign load_val_o = units;

  always_comb begin
    if (!wr_valid_i)    kind_o = WR_NONE;
    else if (|units)    kind_o = WR_LONG;
    else if (frac_nz)   kind_o = WR_SHORT;
    else                kind_o = WR_ZERO;
  end

endmodule

// File: rtl/pause_prescaler.sv
module pause_prescaler #(
  parameter int SHIFT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);

  logic [SHIFT-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pre_q <= '0;
    else if (clr_i) pre_q <= '0;
    else if (en_i)  pre_q <= pre_q + 1'b1;
  end

  assign tick_o = en_i && (pre_q == '1);

  // R7: any load or trap restarts the phase
  a_r7_phase_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> pre_q == '0);

  // R2: phase advances by one per enabled cycle
  a_r2_phase_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !clr_i |=> pre_q == SHIFT'($past(pre_q) + 1'b1));

endmodule

// File: rtl/pause_counter.sv
module pause_counter #(
  parameter int CNT_W = 61
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
  assign last_o = (cnt_q == CNT_W'(1));

  a_r2_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> !zero_o);

  a_r2_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i && !load_i && !clr_i |=> cnt_q == $past(cnt_q) - 1'b1);

  a_r8_full_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !clr_i |=> cnt_q == $past(load_val_i));

  a_r6_trap_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> zero_o);

endmodule

// File: rtl/strand_pause_timer.sv
module strand_pause_timer
  import strand_pause_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SHIFT  = 3,
  localparam int CNT_W = DATA_W - SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              trap_i,
  output logic              stall_o
);

  wr_kind_e         kind;
  logic [CNT_W-1:0] load_val;
  logic             load, pre_clr, pre_en, tick;
  logic             cnt_zero, cnt_last;
  logic             stall_q, stall_d;

  pause_decode #(.DATA_W(DATA_W), .SHIFT(SHIFT)) u_decode (
    .wr_valid_i (wr_valid_i),
    .wr_data_i  (wr_data_i),
    .kind_o     (kind),
    .load_val_o (load_val)
  );

  assign load    = (kind != WR_NONE) && !trap_i;
  assign pre_clr = trap_i || load;
  // only whole units advance the phase; a short stall leaves it at zero
  assign pre_en  = stall_q && !cnt_zero;

  pause_prescaler #(.SHIFT(SHIFT)) u_prescaler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pre_clr),
    .en_i   (pre_en),
    .tick_o (tick)
  );

  pause_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (trap_i),
    .load_i     (load),
    .load_val_i (load_val),
    .dec_i      (tick),
    .zero_o     (cnt_zero),
    .last_o     (cnt_last)
  );

  always_comb begin
    if (trap_i)                    stall_d = 1'b0;
    else if (load)                 stall_d = (kind != WR_ZERO);
    else if (!stall_q)             stall_d = 1'b0;
    else if (cnt_zero)             stall_d = 1'b0;
    else if (tick && cnt_last)     stall_d = 1'b0;
    else                           stall_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stall_q <= 1'b0;
    else         stall_q <= stall_d;
  end

  assign stall_o = stall_q;

  a_r1_idle_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_o |-> cnt_zero);

  a_r6_trap_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> !stall_o);

  a_r5_zero_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && !trap_i && (wr_data_i == '0) |=> !stall_o);

  a_r4_short_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && !trap_i && (wr_data_i != '0) |=> stall_o);

  a_r4_short_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o && cnt_zero && !wr_valid_i && !trap_i |=> !stall_o);

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o && !cnt_zero && !tick && !wr_valid_i && !trap_i |=> stall_o);

endmodule

// File: tb/strand_pause_timer_test.sv
`timescale 1ns/1ps
module strand_pause_timer_test;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        wr_valid;
  logic [63:0] wr_data;
  logic        trap;
  logic        stall;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  strand_pause_timer uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid),
    .wr_data_i  (wr_data),
    .trap_i     (trap),
    .stall_o    (stall)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drives one write cycle; returns at the negedge after the taking edge
  task automatic do_write(input logic [63:0] d, input logic t);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; trap = t;
    @(negedge clk);
    wr_valid = 1'b0; trap = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (stall && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  function automatic int expect_len(input logic [63:0] d);
    if (d == 0) return 0;
    if (d < 8)  return 1;
    return 8 * int'(d >> 3);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 190000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, n_a, n_b;
    rst_ni = 1'b0; wr_valid = 1'b0; wr_data = '0; trap = 1'b0;
    idle(3);
    chk("R1 in reset", stall, 0);
    rst_ni = 1'b1;
    idle(3);
    chk("R1 after reset", stall, 0);

    // sweep every value 0..255 from idle (R2, R3, R4, R5)
    for (int d = 0; d < 256; d++) begin
      do_write(64'(d), 1'b0);
      measure(n);
      if (d == 0)          chk("R5 zero write", n, 0);
      else if (d < 8)      chk("R4 short write", n, 1);
      else if (d % 8 != 0) chk("R3 low bits ignored", n, expect_len(64'(d)));
      else                 chk("R2 whole units", n, expect_len(64'(d)));
      idle(2);
    end

    // R3: paired values differing in low bits only
    do_write(64'd40, 1'b0); measure(n_a); idle(2);
    do_write(64'd47, 1'b0); measure(n_b); idle(2);
    chk("R3 pair 40/47", n_b, n_a);

    // R7: reload with longer and shorter count mid-stall
    do_write(64'd80, 1'b0); idle(29);
    do_write(64'd160, 1'b0); measure(n);
    chk("R7 reload longer", n, 160);
    idle(2);
    do_write(64'd160, 1'b0); idle(13);
    do_write(64'd16, 1'b0); measure(n);
    chk("R7 reload shorter", n, 16);
    idle(2);
    do_write(64'd80, 1'b0); idle(10);
    do_write(64'd3, 1'b0); measure(n);
    chk("R7 small value mid-stall", n, 1);
    idle(2);

    // R5: zero write during a stall
    do_write(64'd80, 1'b0); idle(5);
    do_write(64'd0, 1'b0);
    chk("R5 zero write mid-stall", stall, 0);
    idle(100);
    chk("R5 stays idle", stall, 0);

    // R6: trap mid-stall, and trap with write
    do_write(64'd80, 1'b0); idle(20);
    chk("R6 stalling before trap", stall, 1);
    @(negedge clk); trap = 1'b1;
    @(negedge clk); trap = 1'b0;
    chk("R6 trap ends stall", stall, 0);
    idle(100);
    chk("R6 no resume", stall, 0);
    do_write(64'd80, 1'b1);
    chk("R6 trap beats write", stall, 0);
    idle(10);
    chk("R6 trap beats write later", stall, 0);

    // R8: top bit of the count kept
    do_write(64'h8000_0000_0000_0000, 1'b0);
    idle(2000);
    chk("R8 long stall held", stall, 1);
    @(negedge clk); trap = 1'b1;
    @(negedge clk); trap = 1'b0;
    chk("R8 trap ends long stall", stall, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule